// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Sequencer

This block runs one programmed-I/O bus cycle at a time toward a parallel ATA device. A request names the target device, the direction, whether the cycle addresses a command-block register or moves data, the chip-select pair, the three-bit register address and, for writes, the 16-bit write word. From that the block drives the chip selects, the address, the read or write strobe and the write-data enable. It samples the read word as the strobe closes, and it pulses a completion flag at the end.

Cycle shape comes from four configuration words, one command-cycle word and one data-cycle word for each of the two devices. Each word holds four clock counts: address setup before the strobe, strobe width, hold after the strobe, and recovery before the next cycle. A per-device enable lets a low ready line from the device stretch the strobe. The surrounding controller owns the configuration words and queues the requests. It waits for the completion pulse before it issues the next one.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset and whenever idle, `ide_rd_n` and `ide_wr_n` are 1, `ide_cs_n` is all ones, `ide_wdata_oe` is 0 and `done` is 0.
- R2: A timing word packs four counts, 8 bits each: bits [7:0] setup, [15:8] strobe width, [23:16] hold, [31:24] recovery. `req_is_data`=1 selects the data word and 0 selects the command word. `req_dev` chooses the word of device 0 or of device 1.
- R3: A cycle runs four phases in order. In setup, chip select and address are driven for the setup count with both strobes high. The strobe then stays low for the width count. Chip select and address stay driven for the hold count after the strobe rises. Chip select is then released for the recovery count.
- R4: A count of 0 in any field gives a phase of exactly one clock.
- R5: When `cfg_rdy_en[req_dev]` is 1 and `ide_iordy` is 0 at the last strobe clock, the strobe stays low until a clock where `ide_iordy` is 1. When the enable is 0, `ide_iordy` has no effect.
- R6: For a read, `rdata` takes the value of `ide_rdata` present in the last strobe clock. It then holds that value, through later write cycles too, until the next read completes.
- R7: A write (`req_write`=1) pulses only `ide_wr_n`. `ide_wdata` equals the request word and `ide_wdata_oe` is 1 during the strobe and hold phases. A read pulses only `ide_rd_n`.
- R8: `done` is 1 for exactly one clock, in the first idle clock after recovery ends.
- R9: `req_valid` is accepted only when idle. A request raised during a cycle changes neither the bus outputs of that cycle nor starts a later one.
- R10: `ide_rd_n` and `ide_wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cmd0 | input | 32 | Command-cycle timing word, device 0 |
| cfg_dat0 | input | 32 | Data-cycle timing word, device 0 |
| cfg_cmd1 | input | 32 | Command-cycle timing word, device 1 |
| cfg_dat1 | input | 32 | Data-cycle timing word, device 1 |
| cfg_rdy_en | input | 2 | Ready-wait enable per device |
| req_valid | input | 1 | Start a cycle (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 1 | Target device |
| req_is_data | input | 1 | 1 = data cycle, 0 = command-register cycle |
| req_cs | input | 2 | Chip selects to assert, active high |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write word |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last read word |
| ide_cs_n | output | 2 | Chip selects, active low |
| ide_addr | output | 3 | Device address |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_wdata | output | 16 | Write data toward the device |
| ide_wdata_oe | output | 1 | Write data drive enable |
| ide_rdata | input | 16 | Read data from the device |
| ide_iordy | input | 1 | Device ready |

## Verification
Random cycles mix devices, cycle kinds, directions and four fresh timing words each time. The phase lengths measured at the pins then show whether the right word and field was chosen and whether the phases run in order. Directed cycles with all-zero words separate "zero means one clock" from a skipped or wrapped phase. Ready held low longer and shorter than the strobe width, with the enable set and cleared, shows both the stretch and the case where ready is ignored. A request raised in the middle of a strobe, and read data that changes every clock, check that busy requests are dropped and that the sample is taken in the last strobe clock.

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer #(
  parameter int DW  = 16,
  parameter int CW  = 8,
  parameter int AW  = 3,
  parameter int NCS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4*CW-1:0] cfg_cmd0,
  input  logic [4*CW-1:0] cfg_dat0,
  input  logic [4*CW-1:0] cfg_cmd1,
  input  logic [4*CW-1:0] cfg_dat1,
  input  logic [1:0]      cfg_rdy_en,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_dev,
  input  logic            req_is_data,
  input  logic [NCS-1:0]  req_cs,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [NCS-1:0]  ide_cs_n,
  output logic [AW-1:0]   ide_addr,
  output logic            ide_rd_n,
  output logic            ide_wr_n,
  output logic [DW-1:0]   ide_wdata,
  output logic            ide_wdata_oe,
  input  logic [DW-1:0]   ide_rdata,
  input  logic            ide_iordy
);
  localparam int TW = 4 * CW;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STB, S_HOLD, S_REC} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [TW-1:0]  tw;
  logic           wr_q, rdy_q;
  logic [NCS-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  wd_q;

  function automatic logic [CW-1:0] ld(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  wire [TW-1:0] sel_w = req_dev ? (req_is_data ? cfg_dat1 : cfg_cmd1)
                                : (req_is_data ? cfg_dat0 : cfg_cmd0);
  wire last  = (cnt == '0);
  wire stall = rdy_q && !ide_iordy;
  wire on_bus = (st == S_SETUP) || (st == S_STB) || (st == S_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      tw     <= '0;
      wr_q   <= 1'b0;
      rdy_q  <= 1'b0;
      cs_q   <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_SETUP;
          cnt    <= ld(sel_w[0 +: CW]);
          tw     <= sel_w;
          wr_q   <= req_write;
          rdy_q  <= cfg_rdy_en[req_dev];
          cs_q   <= req_cs;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
        end
        S_SETUP: if (last) begin
          st  <= S_STB;
          cnt <= ld(tw[CW +: CW]);
        end else cnt <= cnt - 1'b1;
        S_STB: if (!last) cnt <= cnt - 1'b1;
        else if (!stall) begin
          st  <= S_HOLD;
          cnt <= ld(tw[2*CW +: CW]);
          if (!wr_q) rdata <= ide_rdata;
        end
        S_HOLD: if (last) begin
          st  <= S_REC;
          cnt <= ld(tw[3*CW +: CW]);
        end else cnt <= cnt - 1'b1;
        S_REC: if (last) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ide_cs_n     = on_bus ? ~cs_q : '1;
  assign ide_addr     = on_bus ? addr_q : '0;
  assign ide_rd_n     = !((st == S_STB) && !wr_q);
  assign ide_wr_n     = !((st == S_STB) && wr_q);
  assign ide_wdata_oe = wr_q && ((st == S_STB) || (st == S_HOLD));
  assign ide_wdata    = ide_wdata_oe ? wd_q : '0;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ide_rd_n && !ide_wr_n)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (ide_rd_n && ide_wr_n && (ide_cs_n == '1) && !ide_wdata_oe)); // R1
  AST_RDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_STB) && last && rdy_q && !ide_iordy) |=> (st == S_STB)); // R5
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STB) |=> $stable(ide_addr)); // R9
  AST_RDATA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_STB) |=> $stable(rdata)); // R6
endmodule

// File: tb/pio_cycle_timer_test.sv
module pio_cycle_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] c0 = '0, d0 = '0, c1 = '0, d1 = '0;
  logic [1:0]  rdy_en = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dev = 1'b0, req_is_data = 1'b0;
  logic [1:0]  req_cs = 2'b01;
  logic [2:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        done;
  logic [15:0] rdata;
  logic [1:0]  ide_cs_n;
  logic [2:0]  ide_addr;
  logic        ide_rd_n, ide_wr_n, ide_wdata_oe;
  logic [15:0] ide_wdata;
  logic [15:0] ide_rdata = '0;
  logic        ide_iordy = 1'b1;

  int total = 0, bad = 0;
  logic [15:0] rd_model = '0;

  always #5 clk = ~clk;

  pio_cycle_timer uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_cmd0(c0), .cfg_dat0(d0), .cfg_cmd1(c1), .cfg_dat1(d1), .cfg_rdy_en(rdy_en),
    .req_valid(req_valid), .req_write(req_write), .req_dev(req_dev), .req_is_data(req_is_data),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata),
    .ide_cs_n(ide_cs_n), .ide_addr(ide_addr), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_wdata(ide_wdata), .ide_wdata_oe(ide_wdata_oe), .ide_rdata(ide_rdata), .ide_iordy(ide_iordy)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int eff(input logic [31:0] w, input int idx);
    int v = int'((w >> (8 * idx)) & 32'hff);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [31:0] rnd_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'($urandom_range(0, 5));
    return w;
  endfunction

  task automatic txn(input bit dev, input bit isd, input bit wr, input logic [1:0] cs,
                     input logic [2:0] ad, input logic [15:0] wd, input int w, input bit inject);
    logic [31:0] tw;
    int ph = 0, ns = 0, nst = 0, nh = 0, nr = 0, es;
    bit bus_err = 0, wd_err = 0, dir_err = 0, seen_done = 0, inj_pending = 0, injected = 0;
    logic [15:0] rd_last = '0;
    tw = dev ? (isd ? d1 : c1) : (isd ? d0 : c0);
    es = eff(tw, 1);
    if (rdy_en[dev] && (w + 1 > es)) es = w + 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_dev = dev; req_is_data = isd;
    req_cs = cs; req_addr = ad; req_wdata = wd; ide_iordy = (w == 0);
    @(negedge clk);
    req_valid = 0;
    for (int g = 0; g < 3000; g++) begin
      if (inj_pending) begin req_valid = 0; inj_pending = 0; end
      if (done) begin seen_done = 1; break; end
      if (!ide_rd_n && !ide_wr_n) dir_err = 1;
      if (ph == 0 && !(wr ? ide_wr_n : ide_rd_n)) ph = 1;
      if (ph == 1 && (wr ? ide_wr_n : ide_rd_n)) ph = 2;
      if (ph == 2 && ide_cs_n == 2'b11) ph = 3;
      if (ph == 1 && !(wr ? ide_rd_n : ide_wr_n)) dir_err = 1;
      if (ph < 3 && (ide_cs_n != ~cs || ide_addr != ad)) bus_err = 1;
      if (wr && (ph == 1 || ph == 2) && (!ide_wdata_oe || ide_wdata != wd)) wd_err = 1;
      if ((!wr || ph == 0 || ph == 3) && ide_wdata_oe) wd_err = 1;
      case (ph)
        0: ns++;
        1: begin
          nst++;
          ide_iordy = (nst > w);
          ide_rdata = 16'($urandom);
          rd_last = ide_rdata;
          if (inject && !injected) begin
            req_valid = 1; req_addr = ~ad; injected = 1; inj_pending = 1;
          end
        end
        2: begin nh++; ide_iordy = 1; end
        default: nr++;
      endcase
      @(negedge clk);
    end
    chk(seen_done, "R8 done seen", seen_done, 1);
    chk(ns == eff(tw, 0), "R2 R3 R4 setup clocks", ns, eff(tw, 0));
    chk(nst == es, "R2 R3 R5 strobe clocks", nst, es);
    chk(nh == eff(tw, 2), "R2 R3 R4 hold clocks", nh, eff(tw, 2));
    chk(nr == eff(tw, 3), "R2 R3 R4 recovery clocks", nr, eff(tw, 3));
    chk(!bus_err, "R3 R9 cs/addr during cycle", bus_err, 0);
    chk(!wd_err, "R7 write data and enable", wd_err, 0);
    chk(!dir_err, "R7 R10 strobe direction", dir_err, 0);
    if (!wr) rd_model = rd_last;
    chk(rdata == rd_model, "R6 read data", rdata, rd_model);
    @(negedge clk);
    chk(!done, "R8 done single clock", done, 0);
    chk(ide_cs_n == 2'b11 && ide_rd_n && ide_wr_n, "R1 R9 idle after cycle", ide_cs_n, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ide_rd_n && ide_wr_n && ide_cs_n == 2'b11 && !ide_wdata_oe && !done,
        "R1 reset state", {ide_rd_n, ide_wr_n, ide_cs_n, ide_wdata_oe, done}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(rdata == 16'h0, "R6 rdata after reset", rdata, 0);

    c0 = 32'h0; d0 = 32'h0; c1 = 32'h0; d1 = 32'h0;
    txn(0, 0, 0, 2'b01, 3'd7, 16'h0, 0, 0);   // R4 all-zero counts
    txn(1, 1, 1, 2'b10, 3'd2, 16'hA5C3, 0, 0);
    c0 = 32'h04_03_02_01; d0 = 32'h01_02_03_04; c1 = 32'h02_05_01_03; d1 = 32'h05_01_04_02;
    rdy_en = 2'b01;
    txn(0, 1, 0, 2'b01, 3'd1, 16'h0, 7, 0);   // R5 stretch past width
    txn(0, 0, 0, 2'b01, 3'd3, 16'h0, 1, 0);   // R5 short low, width wins
    txn(1, 0, 1, 2'b10, 3'd4, 16'h1234, 6, 0); // R5 enable off, ready ignored
    txn(1, 1, 0, 2'b10, 3'd5, 16'h0, 0, 1);   // R9 request during strobe
    txn(0, 0, 1, 2'b01, 3'd6, 16'hBEEF, 0, 1); // R6 write keeps rdata

    for (int n = 0; n < 60; n++) begin
      c0 = rnd_word(); d0 = rnd_word(); c1 = rnd_word(); d1 = rnd_word();
      rdy_en = 2'($urandom);
      txn(1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10,
          3'($urandom), 16'($urandom), $urandom_range(0, 8), ($urandom_range(0, 3) == 0));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule